// File: doc/BRIEF.md
# I2S Stereo Audio Receiver

This block takes a stereo I2S stream and hands 16-bit left and right samples to a playback path, one pair per word-select period, at a 48 kHz frame rate. Each channel slot is either 16 or 32 bit clocks wide. In both widths the sample is the first 16 bits after the slot starts, and the data is sent MSB first.

The block runs in one of two timing roles. As clock master, it divides its system clock (the master clock, 12.288 MHz or 24.576 MHz) down to a bit clock and a word select, and drives both. As slave, it takes bit clock, word select and data from outside through two-flop synchronizers and finds the bit clock edges in the system clock domain. A change to any configuration input restarts the block cleanly.

Each completed frame appears as a one-cycle strobe together with the two parallel samples.

Top module: `i2s_rx_core`

## Requirements
- R1: After synchronous reset, `sample_valid`, `left_out`, `right_out`, `bclk_out` and `ws_out` are all 0.
- R2: In master mode, each bit clock half-period lasts 2 x (2 if `cfg_mclk_hi` else 1) x (1 if `cfg_slot32` else 2) system clocks. This gives 64 x 48 kHz in 32-bit mode and 32 x 48 kHz in 16-bit mode at either master clock rate.
- R3: In master mode, `ws_out` changes only in the cycle where `bclk_out` falls. Once running, it toggles after every 32 (`cfg_slot32`=1) or 16 (`cfg_slot32`=0) bit clock falls. Word select 0 marks the left channel and 1 marks the right channel.
- R4: Data is sampled on bit clock rising edges. The MSB of a channel is the first bit sampled after the rising edge on which a word-select change is seen, and the following bits come in descending order.
- R5: With 32-bit slots, only the first 16 bits of each slot are kept. The remaining 16 bits have no effect on the outputs.
- R6: With 16-bit slots, the LSB of a channel is the bit sampled on the rising edge that also sees the next word-select change. That bit completes the channel.
- R7: `sample_valid` is a one-cycle pulse, raised once per frame after the right channel completes, provided the left channel of the same frame completed before it. `left_out` and `right_out` change only together with that pulse.
- R8: When `cfg_master`=0, `bclk_oe` is 0 and `bclk_out`/`ws_out` stay low. Bit clock, word select and data are taken from `bclk_in`, `ws_in` and `sd_in` through two-flop synchronizers. When `cfg_master`=1, `bclk_oe` is 1.
- R9: A change of any configuration input discards any partial frame. The first `sample_valid` after the change comes only from a left and right pair captured entirely under the new setting.
- R10: After reset or restart, the slot in progress is ignored. Capture begins only after the first word-select change is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System / master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1: generate bit clock and word select; 0: follow external ones |
| cfg_slot32 | input | 1 | 1: 32 bit clocks per channel slot; 0: 16 |
| cfg_mclk_hi | input | 1 | 1: master clock is 24.576 MHz; 0: 12.288 MHz (master divider) |
| bclk_in | input | 1 | External bit clock (slave mode) |
| ws_in | input | 1 | External word select (slave mode) |
| sd_in | input | 1 | Serial audio data |
| bclk_out | output | 1 | Generated bit clock (master mode) |
| ws_out | output | 1 | Generated word select (master mode) |
| bclk_oe | output | 1 | Drive enable for bit clock and word select pins |
| sample_valid | output | 1 | One-cycle strobe for a completed stereo frame |
| left_out | output | 16 | Left channel sample |
| right_out | output | 16 | Right channel sample |

## Verification
With 16-bit slots, one rising edge does two things at once. It shifts in the last bit of the right channel, which completes the frame and raises the strobe. It also sees the word-select change that opens the next left slot and restarts the bit count. The bench provokes this in every 16-bit phase, in both master and slave roles. It judges the result by comparing each frame, and the left sample of the frame that follows, against the values it transmitted. A second overlap is the configuration restart arriving while a left word is already held. The bench checks for this by flagging any strobe that has no fully sent pair behind it.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

    localparam int unsigned SAMPLE_W = 16;
    localparam int unsigned MAX_SLOT = 32;
    localparam int unsigned SLOT_CNT_W = $clog2(2 * MAX_SLOT);
    localparam int unsigned BIT_CNT_W = $clog2(SAMPLE_W + 1);

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    typedef struct packed {
        logic master;
        logic slot32;
        logic mclk_hi;
    } cfg_t;

    // One bit-clock rising event seen in the system clock domain
    typedef struct packed {
        logic rise;
        logic ws;
        logic sd;
    } bit_evt_t;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } frame_t;

    // System clocks per bit clock half period
    function automatic int unsigned half_cycles(input int unsigned base,
                                                input logic fast,
                                                input logic slot32);
        int unsigned h;
        h = base;
        if (fast)
            h = h * 2;
        if (!slot32)
            h = h * 2;
        return h;
    endfunction

endpackage

// File: rtl/i2s_clkgen.sv
module i2s_clkgen
    import i2s_rx_pkg::*;
#(
    parameter int unsigned HALF_BASE = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic restart,
    input  logic fast,
    input  logic slot32,
    output logic bclk,
    output logic ws,
    output logic rise
);

    localparam int unsigned DIV_W = $clog2(HALF_BASE * 4);

    logic [DIV_W-1:0]      div_q;
    logic [DIV_W-1:0]      half_m1;
    logic [SLOT_CNT_W-1:0] bit_q;
    logic [SLOT_CNT_W-1:0] nxt_raw;
    logic [SLOT_CNT_W-1:0] nxt_bit;
    logic                  nxt_ws;
    logic                  bclk_q;
    logic                  ws_q;
    logic                  tick;

    assign half_m1 = DIV_W'(half_cycles(HALF_BASE, fast, slot32) - 1);
    assign tick    = (div_q == half_m1);
    assign nxt_raw = bit_q + 1'b1;

    always_comb begin
        if (slot32) begin
            nxt_bit = nxt_raw;
            nxt_ws  = nxt_raw[SLOT_CNT_W-1];
        end else begin
            nxt_bit = {1'b0, nxt_raw[SLOT_CNT_W-2:0]};
            nxt_ws  = nxt_raw[SLOT_CNT_W-2];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart || !en) begin
            div_q  <= '0;
            bclk_q <= 1'b0;
            ws_q   <= 1'b0;
            bit_q  <= '0;
        end else if (tick) begin
            div_q  <= '0;
            bclk_q <= ~bclk_q;
            if (bclk_q) begin
                bit_q <= nxt_bit;
                ws_q  <= nxt_ws;
            end
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign rise = en && !restart && tick && !bclk_q;
    assign bclk = bclk_q;
    assign ws   = ws_q;

    // R3: word select moves only together with a bit clock fall
    p_ws_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        (ws_q != $past(ws_q)) |-> (($past(bclk_q) && !bclk_q) || $past(restart || !en)));

    // R8: generated pins idle while not master
    p_idle_slave_r8: assert property (@(posedge clk) disable iff (rst)
        (!en && $past(!en)) |-> (!bclk_q && !ws_q));

endmodule

// File: rtl/i2s_frontend.sv
module i2s_frontend
    import i2s_rx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     master,
    input  logic     bclk_in,
    input  logic     ws_in,
    input  logic     sd_in,
    input  logic     m_rise,
    input  logic     m_ws,
    output bit_evt_t evt
);

    localparam int unsigned PINS = 3;

    logic [SYNC_STAGES-1:0][PINS-1:0] stage_q;
    logic [PINS-1:0]                  synced;
    logic                             bclk_d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q  <= '0;
            bclk_d_q <= 1'b0;
        end else begin
            stage_q[0] <= {bclk_in, ws_in, sd_in};
            for (int i = 1; i < SYNC_STAGES; i++)
                stage_q[i] <= stage_q[i-1];
            bclk_d_q <= synced[2];
        end
    end

    assign synced = stage_q[SYNC_STAGES-1];

    always_comb begin
        if (master) begin
            evt.rise = m_rise;
            evt.ws   = m_ws;
            evt.sd   = sd_in;
        end else begin
            evt.rise = synced[2] && !bclk_d_q;
            evt.ws   = synced[1];
            evt.sd   = synced[0];
        end
    end

    // R8: a slave rising event needs a low synchronized clock one cycle earlier
    p_slave_edge_r8: assert property (@(posedge clk) disable iff (rst)
        (!master && evt.rise) |=> !evt.rise);

endmodule

// File: rtl/i2s_deser.sv
module i2s_deser
    import i2s_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     restart,
    input  bit_evt_t evt,
    output logic     valid,
    output frame_t   frame
);

    localparam logic [BIT_CNT_W-1:0] FULL = BIT_CNT_W'(SAMPLE_W);

    logic                 armed_q;
    logic                 last_ws_q;
    logic [BIT_CNT_W-1:0] cnt_q;
    chan_e                chan_q;
    logic [SAMPLE_W-1:0]  shreg_q;
    logic [SAMPLE_W-1:0]  shn;
    logic [SAMPLE_W-1:0]  left_hold_q;
    logic                 left_ok_q;
    logic                 valid_q;
    frame_t               frame_q;

    assign shn = {shreg_q[SAMPLE_W-2:0], evt.sd};

    always_ff @(posedge clk) begin
        valid_q <= 1'b0;
        if (rst || restart) begin
            armed_q     <= 1'b0;
            last_ws_q   <= 1'b0;
            cnt_q       <= FULL;
            chan_q      <= CH_LEFT;
            shreg_q     <= '0;
            left_hold_q <= '0;
            left_ok_q   <= 1'b0;
        end else if (evt.rise) begin
            if (!armed_q) begin
                armed_q   <= 1'b1;
                last_ws_q <= evt.ws;
            end else begin
                if (cnt_q != FULL) begin
                    shreg_q <= shn;
                    cnt_q   <= cnt_q + 1'b1;
                    if (cnt_q == FULL - 1'b1) begin
                        if (chan_q == CH_LEFT) begin
                            left_hold_q <= shn;
                            left_ok_q   <= 1'b1;
                        end else if (left_ok_q) begin
                            frame_q   <= '{left: left_hold_q, right: shn};
                            valid_q   <= 1'b1;
                            left_ok_q <= 1'b0;
                        end
                    end
                end
                if (evt.ws != last_ws_q) begin
                    last_ws_q <= evt.ws;
                    chan_q    <= chan_e'(evt.ws);
                    cnt_q     <= '0;
                end
            end
        end
        if (rst)
            frame_q <= '0;
    end

    assign valid = valid_q;
    assign frame = frame_q;

    // R7: strobe lasts one cycle
    p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    // R4: a frame completes only on a bit clock rising event
    p_valid_on_rise_r4: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> $past(evt.rise));

    // R7: samples hold between strobes
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> ($stable(frame_q.left) && $stable(frame_q.right)));

    // R9: no strobe right after a restart
    p_restart_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        $past(restart) |-> !valid_q);

endmodule

// File: rtl/i2s_rx_core.sv
module i2s_rx_core
    import i2s_rx_pkg::*;
#(
    parameter int unsigned HALF_BASE   = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_master,
    input  logic                cfg_slot32,
    input  logic                cfg_mclk_hi,
    input  logic                bclk_in,
    input  logic                ws_in,
    input  logic                sd_in,
    output logic                bclk_out,
    output logic                ws_out,
    output logic                bclk_oe,
    output logic                sample_valid,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out
);

    cfg_t     cfg_now;
    cfg_t     cfg_q;
    logic     restart;
    logic     m_rise;
    logic     m_ws;
    logic     m_bclk;
    bit_evt_t evt;
    frame_t   frame;

    assign cfg_now = '{master: cfg_master, slot32: cfg_slot32, mclk_hi: cfg_mclk_hi};

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= cfg_now;
        else
            cfg_q <= cfg_now;
    end

    assign restart = (cfg_now != cfg_q);

    i2s_clkgen #(
        .HALF_BASE(HALF_BASE)
    ) u_clkgen (
        .clk    (clk),
        .rst    (rst),
        .en     (cfg_master),
        .restart(restart),
        .fast   (cfg_mclk_hi),
        .slot32 (cfg_slot32),
        .bclk   (m_bclk),
        .ws     (m_ws),
        .rise   (m_rise)
    );

    i2s_frontend #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_frontend (
        .clk    (clk),
        .rst    (rst),
        .master (cfg_master),
        .bclk_in(bclk_in),
        .ws_in  (ws_in),
        .sd_in  (sd_in),
        .m_rise (m_rise),
        .m_ws   (m_ws),
        .evt    (evt)
    );

    i2s_deser u_deser (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .evt    (evt),
        .valid  (sample_valid),
        .frame  (frame)
    );

    assign bclk_out  = m_bclk;
    assign ws_out    = m_ws;
    assign bclk_oe   = cfg_master;
    assign left_out  = frame.left;
    assign right_out = frame.right;

endmodule

// File: tb/sim_i2s_rx_core.sv
module sim_i2s_rx_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tb_master = 1'b1;
    logic        tb_slot32 = 1'b1;
    logic        tb_fast = 1'b0;
    logic        bclk_drv = 1'b0;
    logic        ws_drv = 1'b0;
    logic        sd_drv = 1'b0;
    logic        bclk_out, ws_out, bclk_oe, sample_valid;
    logic [15:0] left_out, right_out;

    always #5 clk = ~clk;

    i2s_rx_core u0 (
        .clk         (clk),
        .rst         (rst),
        .cfg_master  (tb_master),
        .cfg_slot32  (tb_slot32),
        .cfg_mclk_hi (tb_fast),
        .bclk_in     (bclk_drv),
        .ws_in       (ws_drv),
        .sd_in       (sd_drv),
        .bclk_out    (bclk_out),
        .ws_out      (ws_out),
        .bclk_oe     (bclk_oe),
        .sample_valid(sample_valid),
        .left_out    (left_out),
        .right_out   (right_out)
    );

    int          compared = 0;
    int          mismatched = 0;
    logic [31:0] expq[$];
    logic [31:0] lcg = 32'h1234_5678;
    int          seq = 0;
    bit          done = 0;

    // transmitter model state
    logic        tx_ws_last;
    bit          tx_live;
    logic        tx_ch;
    logic [15:0] tx_s;
    logic [31:0] tx_word;
    int          tx_p;
    bit          have_l;
    logic [15:0] l_hold;
    int          pushed;

    function automatic logic [15:0] next_sample();
        logic [15:0] v;
        case (seq)
            0: v = 16'h8000;
            1: v = 16'hFFFF;
            2: v = 16'h0001;
            3: v = 16'h7FFE;
            default: begin
                lcg = lcg * 32'd1103515245 + 32'd12345;
                v = lcg[30:15];
            end
        endcase
        seq++;
        return v;
    endfunction

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic tx_reset();
        tx_ws_last = 1'b0;
        tx_live    = 0;
        tx_ch      = 1'b0;
        tx_word    = '0;
        tx_p       = 99;
        have_l     = 0;
        pushed     = 0;
    endtask

    // Called once per bit clock fall with the word select now in force
    task automatic tx_fall(input logic ws_now, input int slot);
        logic b;
        if (tx_p < slot)
            b = tx_word[slot-1-tx_p];
        else
            b = 1'b0;
        sd_drv = b;
        if (tx_live && tx_p == 15) begin
            if (tx_ch == 1'b0) begin
                l_hold = tx_s;
                have_l = 1;
            end else if (have_l) begin
                expq.push_back({l_hold, tx_s});
                have_l = 0;
                pushed++;
            end
        end
        tx_p++;
        if (ws_now != tx_ws_last) begin
            tx_ws_last = ws_now;
            tx_live    = 1;
            tx_ch      = ws_now;
            tx_s       = next_sample();
            // R5: trailing 16 bits of a 32-bit slot carry non-zero filler
            if (slot == 32)
                tx_word = {tx_s, ~tx_s ^ 16'h3C3C};
            else
                tx_word = {16'h0000, tx_s};
            tx_p = 0;
        end
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_phase(input logic m, input logic s32, input logic f, input int frames);
        int slot;
        int sb;
        slot = s32 ? 32 : 16;
        tb_master = m;
        tb_slot32 = s32;
        tb_fast   = f;
        bclk_drv  = 1'b0;
        ws_drv    = 1'b0;
        sd_drv    = 1'b0;
        tx_reset();
        tick(20);
        if (m) begin
            while (pushed < frames) begin
                @(negedge bclk_out);
                #1;
                tx_fall(ws_out, slot);
            end
        end else begin
            sb = 0;
            while (pushed < frames) begin
                bclk_drv = 1'b1;
                tick(3);
                bclk_drv = 1'b0;
                sb = (sb + 1) % (2 * slot);
                ws_drv = (sb >= slot);
                tx_fall(ws_drv, slot);
                tick(3);
            end
            repeat (4) begin
                bclk_drv = 1'b1;
                tick(3);
                bclk_drv = 1'b0;
                sb = (sb + 1) % (2 * slot);
                ws_drv = (sb >= slot);
                tx_fall(ws_drv, slot);
                tick(3);
            end
        end
        tick(200);
        // R7: every fully sent frame was delivered
        check(expq.size() == 0, "R7 frames outstanding", expq.size(), 0);
        expq.delete();
    endtask

    // per-clock monitor, sampled away from the active edge
    int   cyc = 0;
    int   settle = 0;
    logic [2:0] cfg_prev = '0;
    logic b_prev = 1'b0, w_prev = 1'b0;
    bit   tog_arm = 0, ws_arm = 0;
    int   tcnt = 0, falls = 0;

    always @(negedge clk) begin
        logic [31:0] e;
        int exp_half;
        string tag;
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
        if (rst) begin
            settle = 0;
        end else begin
            if ({tb_master, tb_slot32, tb_fast} != cfg_prev)
                settle = 0;
            else if (settle < 100)
                settle++;
            cfg_prev = {tb_master, tb_slot32, tb_fast};

            if (sample_valid) begin
                if (expq.size() == 0) begin
                    check(0, "R9 R10 strobe without complete frame", {left_out, right_out}, 0);
                end else begin
                    e = expq.pop_front();
                    if (!tb_master) tag = "R4 R8 slave frame";
                    else if (tb_slot32) tag = "R4 R5 32-bit frame";
                    else tag = "R4 R6 16-bit frame";
                    check({left_out, right_out} == e, tag, {left_out, right_out}, e);
                end
            end

            check(bclk_oe == tb_master, "R8 drive enable", bclk_oe, tb_master);

            if (!tb_master && settle >= 2)
                check(!bclk_out && !ws_out, "R8 master pins idle", {bclk_out, ws_out}, 0);

            if (tb_master && settle >= 2) begin
                exp_half = 2 * (tb_fast ? 2 : 1) * (tb_slot32 ? 1 : 2);
                if (bclk_out != b_prev) begin
                    if (tog_arm)
                        check(tcnt == exp_half, "R2 half period", tcnt, exp_half);
                    tog_arm = 1;
                    tcnt = 1;
                    if (b_prev && !bclk_out)
                        falls++;
                end else begin
                    tcnt++;
                end
                if (ws_out != w_prev) begin
                    check(b_prev && !bclk_out, "R3 ws moves on fall", {b_prev, bclk_out}, 2'b10);
                    if (ws_arm)
                        check(falls == (tb_slot32 ? 32 : 16), "R3 slot length", falls,
                              tb_slot32 ? 32 : 16);
                    ws_arm = 1;
                    falls = 0;
                end
            end else begin
                tog_arm = 0;
                ws_arm = 0;
                tcnt = 0;
                falls = 0;
            end
            b_prev = bclk_out;
            w_prev = ws_out;
        end
    end

    initial begin
        tx_reset();
        tick(4);
        // R1: reset state
        check(!sample_valid && left_out == 0 && right_out == 0 && !bclk_out && !ws_out,
              "R1 reset outputs", {sample_valid, bclk_out, ws_out, left_out[12:0], right_out},
              0);
        rst = 1'b0;
        tick(2);

        // R2 R3 R5: master 32-bit at 12.288 MHz
        run_phase(1'b1, 1'b1, 1'b0, 4);
        // R6 R9: master 16-bit, restart while a left word is held
        run_phase(1'b1, 1'b0, 1'b0, 4);
        // R2: master 32-bit at 24.576 MHz
        run_phase(1'b1, 1'b1, 1'b1, 3);
        // R2 R6: master 16-bit at 24.576 MHz
        run_phase(1'b1, 1'b0, 1'b1, 3);
        // R8 R10: slave 16-bit, then slave 32-bit
        run_phase(1'b0, 1'b0, 1'b0, 4);
        run_phase(1'b0, 1'b1, 1'b0, 3);
        // R9: back to master after slave
        run_phase(1'b1, 1'b0, 1'b0, 3);

        // R1: reset again after traffic
        rst = 1'b1;
        tick(3);
        check(!sample_valid && left_out == 0 && right_out == 0 && !bclk_out && !ws_out,
              "R1 reset after traffic", {left_out, right_out}, 0);
        rst = 1'b0;
        tick(2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule